// File: doc/BRIEF.md
# Double-Banked Spectral Multiply-Accumulator

This block builds one cross-spectrum element per frequency channel out of two streams of FFT output samples. Each sample is a small complex number in block-floating-point form: a 4-bit real part and a 4-bit imaginary part, both two's complement, that share an unsigned 4-bit exponent. For every channel the block multiplies the first stream by the complex conjugate of the second. It sums the products over a programmable number of FFT frames into a 36-bit word made of a 15-bit real part, a 15-bit imaginary part and a 6-bit exponent. When the same stream is fed to both ports, the result is a self-spectrum.

The accumulation storage has two banks, each with one word per channel. While one integration fills one bank, the result of the previous integration is held in the other bank. The block reads that result out one word per idle cycle, using the gap cycles that each FFT frame leaves between its last sample and the next frame's first sample. The upstream pipeline marks each frame's first sample with `frame_start` and qualifies every sample with `in_valid`. A downstream collector takes the words from the readout port.

Top module: `smac_top`

## Requirements
- R1: After reset no readout word is produced (`rd_valid` stays low) until an integration has completed.
- R2: Each input word packs the real mantissa in bits [3:0], the imaginary mantissa in bits [7:4] (both two's complement) and the unsigned exponent in bits [11:8]. The product of A and the conjugate of B has real part ar*br+ai*bi, imaginary part ai*br-ar*bi and exponent ae+be.
- R3: On the first frame of an integration each channel's word is loaded with the new product, so earlier contents of that bank have no effect on the result.
- R4: On later frames the running word and the product are aligned to the larger of the two exponents. The mantissas with the smaller exponent are arithmetically shifted right (rounding toward minus infinity) by the exponent difference before they are added.
- R5: When the aligned sum of either part leaves the 15-bit signed range [-16384, 16383], both parts are shifted right by one bit (rounding toward minus infinity) and the exponent is increased by one.
- R6: `frame_start` sets the channel index of its sample to 0, and each later valid sample takes the next index. An integration ends with channel CHAN-1 of frame `n_frames`. A `n_frames` of 0 behaves as 1.
- R7: At the end of an integration the banks swap. The finished bank is read out while the next integration fills the other bank, and the words read out are not affected by that ongoing integration.
- R8: Readout words are fetched only in cycles with `in_valid` low, one per such cycle, in ascending channel order from 0 to CHAN-1. Each word appears on the port one clock after the idle cycle that fetched it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies a sample pair on a_in and b_in |
| frame_start | input | 1 | Marks the sample pair of channel 0 |
| a_in | input | 12 | Stream A sample {exp, im, re} |
| b_in | input | 12 | Stream B sample {exp, im, re}, conjugated |
| n_frames | input | 14 | Frames per integration (0 acts as 1) |
| rd_valid | output | 1 | Readout word valid |
| rd_chan | output | 8 | Channel of the readout word |
| rd_re | output | 15 | Accumulated real part |
| rd_im | output | 15 | Accumulated imaginary part |
| rd_exp | output | 6 | Accumulated exponent |

## Verification
A sample is folded into its channel word at the clock edge that accepts it, so an integration's result is complete at the edge that takes channel CHAN-1 of its last frame. From the first idle cycle after that edge, each idle cycle fetches one word, and the word is on the port one edge later. The bench drives inputs just after a rising edge and samples the readout port at the falling edge. For each word it checks that the cycle before held `in_valid` low, that the channel follows the expected ascending order, and that the value equals a snapshot its own model took when the integration's last sample was driven. Each test then idles long enough for a full bank to drain before counting the result sets that came out.

// File: rtl/smac_pkg.sv
package smac_pkg;
  parameter int MANT_W = 4;
  parameter int IEXP_W = 4;
  parameter int IN_W   = 2 * MANT_W + IEXP_W;
  parameter int ACC_W  = 15;
  parameter int AEXP_W = 6;
  parameter int PROD_W = 2 * MANT_W + 1;

  typedef struct packed {
    logic [IEXP_W-1:0]        ex;
    logic signed [MANT_W-1:0] im;
    logic signed [MANT_W-1:0] re;
  } bfp_t;

  typedef struct packed {
    logic signed [ACC_W-1:0] re;
    logic signed [ACC_W-1:0] im;
    logic [AEXP_W-1:0]       ex;
  } acc_t;

  // a * conj(b), exponents add
  function automatic acc_t conj_mul(bfp_t a, bfp_t b);
    logic signed [PROD_W-1:0] ar, ai, br, bi, pr, pim;
    acc_t r;
    ar  = PROD_W'($signed(a.re));
    ai  = PROD_W'($signed(a.im));
    br  = PROD_W'($signed(b.re));
    bi  = PROD_W'($signed(b.im));
    pr  = ar * br + ai * bi;
    pim = ai * br - ar * bi;
    r.re = ACC_W'(pr);
    r.im = ACC_W'(pim);
    r.ex = AEXP_W'(a.ex) + AEXP_W'(b.ex);
    return r;
  endfunction

  // widen by one bit, then arithmetic shift right
  function automatic logic signed [ACC_W:0] align(logic signed [ACC_W-1:0] m,
                                                  logic [AEXP_W-1:0] sh);
    logic signed [ACC_W:0] w;
    w = {m[ACC_W-1], m};
    return w >>> sh;
  endfunction

  // aligned add with single-step renormalisation
  function automatic acc_t accumulate(acc_t old, acc_t p);
    logic [AEXP_W-1:0]     e, so, sp;
    logic signed [ACC_W:0] sr, si;
    logic                  ovf;
    acc_t                  r;
    if (old.ex >= p.ex) begin
      e  = old.ex;
      so = '0;
      sp = old.ex - p.ex;
    end else begin
      e  = p.ex;
      sp = '0;
      so = p.ex - old.ex;
    end
    sr  = align(old.re, so) + align(p.re, sp);
    si  = align(old.im, so) + align(p.im, sp);
    ovf = (sr[ACC_W] != sr[ACC_W-1]) || (si[ACC_W] != si[ACC_W-1]);
    if (ovf) begin
      r.re = sr[ACC_W:1];
      r.im = si[ACC_W:1];
      r.ex = e + AEXP_W'(1);
    end else begin
      r.re = sr[ACC_W-1:0];
      r.im = si[ACC_W-1:0];
      r.ex = e;
    end
    return r;
  endfunction
endpackage

// File: rtl/smac_cmul.sv
module smac_cmul
  import smac_pkg::*;
(
  input  logic [IN_W-1:0] a_word,
  input  logic [IN_W-1:0] b_word,
  output acc_t            prod
);
  bfp_t a_f, b_f;
  assign a_f  = bfp_t'(a_word);
  assign b_f  = bfp_t'(b_word);
  assign prod = conj_mul(a_f, b_f);
endmodule

// File: rtl/smac_accum.sv
module smac_accum
  import smac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic first,
  input  acc_t old_val,
  input  acc_t prod,
  output acc_t new_val
);
  acc_t summed;
  assign summed  = accumulate(old_val, prod);
  assign new_val = first ? prod : summed;

  // R4/R5: alignment never lowers the running exponent
  assert_exp_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !first) |-> (new_val.ex >= old_val.ex));
endmodule

// File: rtl/smac_ctrl.sv
module smac_ctrl #(
  parameter int CHAN = 256,
  parameter int NF_W = 14,
  localparam int CH_W = $clog2(CHAN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            frame_start,
  input  logic [NF_W-1:0] n_frames,
  output logic [CH_W-1:0] ch,
  output logic            bank,
  output logic            first,
  output logic            swap
);
  logic [CH_W-1:0] ch_q;
  logic [NF_W-1:0] frm_q;
  logic            bank_q;
  logic            ch_last, frame_last;

  assign ch         = frame_start ? '0 : ch_q;
  assign ch_last    = (ch == CH_W'(CHAN - 1));
  assign frame_last = ({1'b0, frm_q} + (NF_W+1)'(1)) >= {1'b0, n_frames};
  assign first      = (frm_q == '0);
  assign swap       = in_valid && ch_last && frame_last;
  assign bank       = bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q   <= '0;
      frm_q  <= '0;
      bank_q <= 1'b0;
    end else if (in_valid) begin
      ch_q <= ch_last ? '0 : ch + CH_W'(1);
      if (ch_last) begin
        frm_q  <= frame_last ? '0 : frm_q + NF_W'(1);
        bank_q <= bank_q ^ frame_last;
      end
    end
  end

  // R6: banks only change at an accepted sample
  assert_swap_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q != $past(bank_q)) |-> $past(in_valid));
endmodule

// File: rtl/smac_drain.sv
module smac_drain
  import smac_pkg::*;
#(
  parameter int CHAN = 256,
  localparam int CH_W = $clog2(CHAN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            swap,
  input  logic            wr_bank,
  input  logic            in_valid,
  input  acc_t            rdata,
  output logic [CH_W:0]   raddr,
  output logic            busy,
  output logic            rd_bank,
  output logic            rd_valid,
  output logic [CH_W-1:0] rd_chan,
  output acc_t            rd_word
);
  logic [CH_W-1:0] ptr;
  logic            busy_q, dbank, fetch;

  assign fetch   = busy_q && !in_valid;
  assign raddr   = {dbank, ptr};
  assign busy    = busy_q;
  assign rd_bank = dbank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      ptr      <= '0;
      dbank    <= 1'b0;
      rd_valid <= 1'b0;
      rd_chan  <= '0;
      rd_word  <= '0;
    end else begin
      rd_valid <= fetch;
      if (fetch) begin
        rd_chan <= ptr;
        rd_word <= rdata;
      end
      if (swap) begin
        busy_q <= 1'b1;
        ptr    <= '0;
        dbank  <= wr_bank;
      end else if (fetch) begin
        ptr <= ptr + CH_W'(1);
        if (ptr == CH_W'(CHAN - 1)) busy_q <= 1'b0;
      end
    end
  end

  // R8: every readout word was fetched in an idle cycle
  assert_read_in_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!in_valid));
endmodule

// File: rtl/smac_top.sv
module smac_top
  import smac_pkg::*;
#(
  parameter int CHAN = 256,
  parameter int NF_W = 14,
  localparam int CH_W = $clog2(CHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              frame_start,
  input  logic [IN_W-1:0]   a_in,
  input  logic [IN_W-1:0]   b_in,
  input  logic [NF_W-1:0]   n_frames,
  output logic              rd_valid,
  output logic [CH_W-1:0]   rd_chan,
  output logic [ACC_W-1:0]  rd_re,
  output logic [ACC_W-1:0]  rd_im,
  output logic [AEXP_W-1:0] rd_exp
);
  localparam int DEPTH = 2 * CHAN;

  acc_t mem [0:DEPTH-1];

  logic [CH_W-1:0] ch;
  logic            bank, first, swap;
  logic [CH_W:0]   wr_addr, rd_addr;
  acc_t            old_val, prod, new_val, drain_data, rd_word;
  logic            drain_busy, drain_bank;

  smac_ctrl #(.CHAN(CHAN), .NF_W(NF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
    .n_frames(n_frames), .ch(ch), .bank(bank), .first(first), .swap(swap)
  );

  assign wr_addr = {bank, ch};
  assign old_val = mem[wr_addr];

  smac_cmul u_cmul (.a_word(a_in), .b_word(b_in), .prod(prod));

  smac_accum u_accum (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .first(first),
    .old_val(old_val), .prod(prod), .new_val(new_val)
  );

  always_ff @(posedge clk) begin
    if (in_valid) mem[wr_addr] <= new_val;
  end

  assign drain_data = mem[rd_addr];

  smac_drain #(.CHAN(CHAN)) u_drain (
    .clk(clk), .rst_n(rst_n), .swap(swap), .wr_bank(bank), .in_valid(in_valid),
    .rdata(drain_data), .raddr(rd_addr), .busy(drain_busy), .rd_bank(drain_bank),
    .rd_valid(rd_valid), .rd_chan(rd_chan), .rd_word(rd_word)
  );

  assign rd_re  = rd_word.re;
  assign rd_im  = rd_word.im;
  assign rd_exp = rd_word.ex;

  // R7: the bank being read out is never the one being written
  assert_bank_isolation_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && drain_busy) |-> (bank != drain_bank));
endmodule

// File: tb/smac_top_test.sv
`timescale 1ns/1ps
module smac_top_test;
  localparam int CHAN = 8;
  localparam int NF_W = 14;
  localparam int GAP  = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        frame_start = 0;
  logic [11:0] a_in = '0, b_in = '0;
  logic [NF_W-1:0] n_frames = '0;
  logic        rd_valid;
  logic [2:0]  rd_chan;
  logic [14:0] rd_re, rd_im;
  logic [5:0]  rd_exp;

  always #2.5 clk = ~clk;

  smac_top #(.CHAN(CHAN), .NF_W(NF_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
    .a_in(a_in), .b_in(b_in), .n_frames(n_frames), .rd_valid(rd_valid),
    .rd_chan(rd_chan), .rd_re(rd_re), .rd_im(rd_im), .rd_exp(rd_exp)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // model state
  int mre[CHAN], mim[CHAN], mex[CHAN];
  int snre[2][CHAN], snim[2][CHAN], snex[2][CHAN];
  int prod_slot = 0, drain_slot = 0, exp_ch = 0, sets = 0, words = 0, gap_err = 0;
  int cap_re[CHAN], cap_im[CHAN], cap_ex[CHAN];
  bit prev_iv = 0;

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int shr(int v, int s);
    int r = v;
    for (int k = 0; k < s && k < 40; k++) r = r >>> 1;
    return r;
  endfunction

  task automatic model_add(int c, logic [11:0] a, logic [11:0] b, bit first);
    int ar, ai, ae, br, bi, be, pr, pi, pe, e, sr, si;
    ar = int'($signed(a[3:0])); ai = int'($signed(a[7:4])); ae = int'(a[11:8]);
    br = int'($signed(b[3:0])); bi = int'($signed(b[7:4])); be = int'(b[11:8]);
    pr = ar * br + ai * bi;
    pi = ai * br - ar * bi;
    pe = ae + be;
    if (first) begin
      mre[c] = pr; mim[c] = pi; mex[c] = pe;
    end else begin
      e  = (mex[c] > pe) ? mex[c] : pe;
      sr = shr(mre[c], e - mex[c]) + shr(pr, e - pe);
      si = shr(mim[c], e - mex[c]) + shr(pi, e - pe);
      if (sr > 16383 || sr < -16384 || si > 16383 || si < -16384) begin
        sr = shr(sr, 1); si = shr(si, 1); e = e + 1;
      end
      mre[c] = sr; mim[c] = si; mex[c] = e;
    end
  endtask

  function automatic logic [11:0] gen(int t, int f, int c, int side);
    int h;
    if (t == 1 && c == 0) return side ? 12'h2F1 : 12'h123;
    if (t == 5) return 12'h088;
    if (t == 7 && c == 0) return 12'h001;
    h = (t * 1103 + f * 389 + c * 71 + side * 613) % 4093;
    h = (h * 37 + 11) % 4093;
    return {4'(h % 6), 4'(h >> 4), 4'(h >> 8)};
  endfunction

  // readout monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      words++;
      check("R8", "fetched in idle cycle", int'(prev_iv), 0);
      check("R8", "channel order", int'(rd_chan), exp_ch);
      check(cur_req, "re", int'($signed(rd_re)), snre[drain_slot][rd_chan]);
      check(cur_req, "im", int'($signed(rd_im)), snim[drain_slot][rd_chan]);
      check(cur_req, "exp", int'(rd_exp), snex[drain_slot][rd_chan]);
      cap_re[rd_chan] = int'($signed(rd_re));
      cap_im[rd_chan] = int'($signed(rd_im));
      cap_ex[rd_chan] = int'(rd_exp);
      exp_ch++;
      if (exp_ch == CHAN) begin
        exp_ch = 0; drain_slot ^= 1; sets++;
      end
    end
    prev_iv = in_valid;
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 0; frame_start = 0;
    end
  endtask

  task automatic send_frame(int t, int f, bit first, bit last);
    for (int c = 0; c < CHAN; c++) begin
      @(posedge clk); #1;
      in_valid = 1; frame_start = (c == 0);
      a_in = gen(t, f, c, 0); b_in = gen(t, f, c, 1);
      model_add(c, a_in, b_in, first);
    end
    if (last) begin
      for (int c = 0; c < CHAN; c++) begin
        snre[prod_slot][c] = mre[c]; snim[prod_slot][c] = mim[c]; snex[prod_slot][c] = mex[c];
      end
      prod_slot ^= 1;
    end
    idle(GAP);
  endtask

  task automatic run_integ(int t, int nf, int nset);
    n_frames = NF_W'(nset);
    for (int f = 0; f < nf; f++) send_frame(t, f, f == 0, f == nf - 1);
  endtask

  task automatic t_reset;
    cur_req = "R1";
    idle(3 * CHAN);
    check("R1", "words before any integration", words, 0);
  endtask

  task automatic t_single;
    int s0 = sets;
    cur_req = "R2";
    run_integ(1, 1, 1);
    idle(3 * CHAN);
    check("R2", "sets drained", sets - s0, 1);
    check("R2", "ch0 re", cap_re[0], 1);
    check("R2", "ch0 im", cap_im[0], 5);
    check("R2", "ch0 exp", cap_ex[0], 3);
  endtask

  task automatic t_nzero;
    int s0 = sets;
    cur_req = "R6";
    run_integ(2, 1, 0);
    idle(3 * CHAN);
    check("R6", "n_frames 0 acts as 1", sets - s0, 1);
  endtask

  task automatic t_accum;
    int s0 = sets;
    cur_req = "R4";
    run_integ(3, 5, 5);
    idle(3 * CHAN);
    check("R4", "sets drained", sets - s0, 1);
  endtask

  task automatic t_ovf;
    int s0 = sets;
    cur_req = "R5";
    run_integ(5, 200, 200);
    idle(3 * CHAN);
    check("R5", "sets drained", sets - s0, 1);
    check("R5", "ch3 re after renormalise", cap_re[3], 12800);
    check("R5", "ch3 im", cap_im[3], 0);
    check("R5", "ch3 exp", cap_ex[3], 1);
  endtask

  task automatic t_pingpong;
    int s0 = sets;
    cur_req = "R7";
    run_integ(6, 2, 2);
    run_integ(7, 2, 2);
    check("R7", "first set drained during next integration", sets - s0, 1);
    cur_req = "R3";
    idle(3 * CHAN);
    check("R7", "sets drained", sets - s0, 2);
    check("R3", "ch0 re loaded fresh", cap_re[0], 2);
    check("R3", "ch0 exp loaded fresh", cap_ex[0], 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_single();
    t_nzero();
    t_accum();
    t_ovf();
    t_pingpong();
    check("R8", "total words", words, 6 * CHAN);
    check("R8", "partial set left", exp_ch, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule